// File: doc/BRIEF.md
# Byte Stream to Wide Word Deserializer with Control-Character Framing

This block sits behind the receive path of a serial transceiver, after 8b/10b decoding and word alignment. One decoded byte arrives on every receive clock. With each byte come a flag that marks it as a control character, a running-disparity error flag and a code-violation flag. The block rebuilds user words of `VEC_W` bits from these bytes. `VEC_W` is a parameter and is rounded up to a whole number of bytes.

Any control character puts the block into synchronization: the byte count returns to zero and the control byte itself is never stored. Data bytes that follow are shifted into an assembly register 8 bits at a time. When the last byte of a word arrives, the assembled word appears on the output with a strobe that lasts exactly one cycle. The user must capture the word on that cycle. From reset until the first control character, data bytes are dropped. A separate one-cycle error strobe reports data bytes that the decoder flagged as bad.

Top module: `byte_vec_deser`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `word_valid` is 0, `byte_err` is 0 and `word_out` is all zeros.
- R2: Let NB be ceil(VEC_W/8) (3 for the default VEC_W of 20). Once framing is established, every NB consecutive data bytes complete exactly one word.
- R3: When `rx_is_ctrl` is 1, the byte is not stored and the byte count restarts at zero. A partial word that was being assembled is discarded and never reported.
- R4: The first data byte after a control character supplies the most significant bits of the word. Bytes are concatenated in arrival order into an 8*NB-bit value, and `word_out` is its low VEC_W bits. The top 8*NB-VEC_W bits of the first byte are padding and are dropped.
- R5: `word_valid` is 1 for exactly one cycle. That cycle is the one immediately after the clock edge that sampled the last byte of a word. `word_out` changes only in that cycle and holds its value until the next word completes.
- R6: Words follow one another back to back with no control character between them. The byte after a completed word starts the next word.
- R7: `byte_err` is 1 for exactly the cycle after a byte was sampled with `rx_is_ctrl`=0 and either `rx_disp_err` or `rx_code_err` set. Flags that arrive on a control byte never raise `byte_err`.
- R8: After reset, data bytes received before the first control character are ignored and produce no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Decoded byte, one per clock |
| rx_is_ctrl | input | 1 | 1: byte is a control character |
| rx_disp_err | input | 1 | Disparity error reported for this byte |
| rx_code_err | input | 1 | Code violation reported for this byte |
| word_out | output | VEC_W | Last completed word |
| word_valid | output | 1 | One-cycle strobe for a new word |
| byte_err | output | 1 | One-cycle strobe for a flagged data byte |

## Verification
The assertions check these properties on every cycle:
- the byte counter stays within NB;
- a control character leaves framing established with the count at zero;
- a final byte is always followed by the strobe;
- the strobe never lasts two cycles;
- the word is stable whenever the strobe is low;
- a control byte never raises the error strobe.

Byte ordering, padding removal, dropping of data before the first control character, and discarding of interrupted partial words show up only in data values. The bench's scenarios cover these against an arithmetic model of byte concatenation.

// File: rtl/deser_pkg.sv
package deser_pkg;

  // Whole bytes needed to carry a word of the given bit width.
  function automatic int unsigned bytes_for(input int unsigned bits);
    return (bits + 7) / 8;
  endfunction

  // Counter width able to hold 0 .. n-1.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl #(
  parameter int unsigned NBYTES = 3,
  parameter int unsigned CW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_ctrl,
  output logic          take_byte,
  output logic          last_byte,
  output logic          framed,
  output logic [CW-1:0] byte_idx
);

  localparam logic [CW-1:0] LAST_IDX = CW'(NBYTES - 1);

  logic          framed_q;
  logic [CW-1:0] idx_q;

  assign take_byte = framed_q && !is_ctrl;
  assign last_byte = take_byte && (idx_q == LAST_IDX);
  assign framed    = framed_q;
  assign byte_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      framed_q <= 1'b0;
      idx_q    <= '0;
    end else if (is_ctrl) begin
      framed_q <= 1'b1;
      idx_q    <= '0;
    end else if (take_byte) begin
      idx_q <= last_byte ? '0 : idx_q + 1'b1;
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX); // R2

  AST_CTRL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctrl |=> (framed_q && idx_q == '0)); // R3

  AST_UNFRAMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !framed_q |-> (idx_q == '0)); // R8

endmodule

// File: rtl/vec_shifter.sv
module vec_shifter #(
  parameter int unsigned VEC_W  = 20,
  parameter int unsigned NBYTES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       byte_in,
  input  logic             take,
  input  logic             last,
  output logic [VEC_W-1:0] word_out,
  output logic             word_valid
);

  localparam int unsigned SW = NBYTES * 8;

  logic [SW-1:0]    acc_q;
  logic [SW-1:0]    acc_next;
  logic [VEC_W-1:0] word_q;
  logic             valid_q;

  generate
    if (NBYTES > 1) begin : g_multi
      assign acc_next = {acc_q[SW-9:0], byte_in};
    end else begin : g_single
      assign acc_next = byte_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take && last;
      if (take) acc_q <= acc_next;
      if (take && last) word_q <= acc_next[VEC_W-1:0];
    end
  end

  assign word_out   = word_q;
  assign word_valid = valid_q;

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(word_q)); // R5

  generate
    if (NBYTES > 1) begin : g_pulse_chk
      AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q); // R5
    end
  endgenerate

endmodule

// File: rtl/rx_err_flag.sv
module rx_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic is_ctrl,
  input  logic disp_err,
  input  logic code_err,
  output logic err_pulse
);

  logic err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= !is_ctrl && (disp_err || code_err);
  end

  assign err_pulse = err_q;

  AST_CTRL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctrl |=> !err_q); // R7

endmodule

// File: rtl/byte_vec_deser.sv
module byte_vec_deser
  import deser_pkg::*;
#(
  parameter int unsigned VEC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_byte,
  input  logic             rx_is_ctrl,
  input  logic             rx_disp_err,
  input  logic             rx_code_err,
  output logic [VEC_W-1:0] word_out,
  output logic             word_valid,
  output logic             byte_err
);

  localparam int unsigned NBYTES = bytes_for(VEC_W);
  localparam int unsigned CW     = idx_width(NBYTES);

  // Internal events brought out for the checks below.
  logic          take_byte;
  logic          last_byte;
  logic          framed;
  logic [CW-1:0] byte_idx;

  rx_frame_ctrl #(.NBYTES(NBYTES), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_ctrl   (rx_is_ctrl),
    .take_byte (take_byte),
    .last_byte (last_byte),
    .framed    (framed),
    .byte_idx  (byte_idx)
  );

  vec_shifter #(.VEC_W(VEC_W), .NBYTES(NBYTES)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_in    (rx_byte),
    .take       (take_byte),
    .last       (last_byte),
    .word_out   (word_out),
    .word_valid (word_valid)
  );

  rx_err_flag u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_ctrl   (rx_is_ctrl),
    .disp_err  (rx_disp_err),
    .code_err  (rx_code_err),
    .err_pulse (byte_err)
  );

  AST_LAST_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> word_valid); // R2

  AST_NO_WORD_UNFRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!framed && !rx_is_ctrl) |=> !word_valid); // R8

  AST_WRAP_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && byte_idx != '0) |=> (framed && byte_idx == '0)); // R6

endmodule

// File: tb/byte_vec_deser_test.sv
`timescale 1ns/1ps
module byte_vec_deser_test;

  localparam int unsigned VEC_W = 20;
  localparam int unsigned NB    = (VEC_W + 7) / 8;
  localparam int unsigned SW    = NB * 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       rx_byte = '0;
  logic             rx_is_ctrl = 1'b0;
  logic             rx_disp_err = 1'b0;
  logic             rx_code_err = 1'b0;
  logic [VEC_W-1:0] word_out;
  logic             word_valid;
  logic             byte_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // Bench model state
  bit               m_framed = 1'b0;
  int               m_idx    = 0;
  logic [SW-1:0]    m_acc    = '0;
  logic [VEC_W-1:0] m_word   = '0;
  int               m_words  = 0;

  always #5 clk = ~clk;

  byte_vec_deser #(.VEC_W(VEC_W)) uut (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_is_ctrl(rx_is_ctrl),
    .rx_disp_err(rx_disp_err), .rx_code_err(rx_code_err),
    .word_out(word_out), .word_valid(word_valid), .byte_err(byte_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive one byte, step one cycle, check at the next falling edge.
  task automatic step(input logic [7:0] b, input bit c, input bit d, input bit e, input string vtag);
    bit exp_v;
    bit exp_e;
    rx_byte = b; rx_is_ctrl = c; rx_disp_err = d; rx_code_err = e;
    exp_v = 1'b0;
    exp_e = !c && (d || e);
    if (c) begin
      m_framed = 1'b1;
      m_idx = 0;
    end else if (m_framed) begin
      m_acc = (m_acc << 8) | SW'(b);
      if (m_idx == NB - 1) begin
        exp_v = 1'b1;
        m_word = m_acc[VEC_W-1:0];
        m_words++;
        m_idx = 0;
      end else begin
        m_idx++;
      end
    end
    @(negedge clk);
    chk(vtag, 32'(word_valid), 32'(exp_v));
    chk("R4", 32'(word_out), 32'(m_word));
    chk("R7", 32'(byte_err), 32'(exp_e));
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: state while reset is held
    chk("R1", 32'(word_valid), 32'd0);
    chk("R1", 32'(byte_err), 32'd0);
    chk("R1", 32'(word_out), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 32'(word_valid), 32'd0);
    chk("R1", 32'(word_out), 32'd0);

    // R8: data before any control character is dropped
    for (int i = 0; i < 2 * NB + 1; i++)
      step(8'(8'hA0 + i), 1'b0, i[0], i[1], "R8");

    // R7: flags on a control byte raise no error
    step(8'hBC, 1'b1, 1'b1, 1'b1, "R3");

    // R2/R6: long back-to-back sweep across all byte values
    for (int i = 0; i < 256 * NB; i++)
      step(8'((i * 37 + 11) & 8'hFF), 1'b0, 1'b0, 1'b0, "R2");

    // R3: interrupt a word after each possible number of bytes
    for (int k = 0; k < NB; k++) begin
      step(8'h3C, 1'b1, 1'b0, 1'b0, "R3");
      for (int j = 0; j < k; j++) step(8'(8'hE0 + j), 1'b0, 1'b0, 1'b0, "R3");
      step(8'hBC, 1'b1, 1'b0, 1'b0, "R3");
      for (int j = 0; j < NB; j++) step(8'(8'h10 * (k + 1) + j), 1'b0, 1'b0, 1'b0, "R3");
    end

    // R4: explicit ordering and padding, computed independently
    step(8'hBC, 1'b1, 1'b0, 1'b0, "R3");
    step(8'hF7, 1'b0, 1'b0, 1'b0, "R4");
    step(8'h5A, 1'b0, 1'b0, 1'b0, "R4");
    step(8'hC3, 1'b0, 1'b0, 1'b0, "R4");
    chk("R4", 32'(word_out), 32'h75AC3);

    // R5: word holds across idle control characters
    for (int i = 0; i < 4; i++) step(8'hBC, 1'b1, 1'b0, 1'b0, "R5");
    chk("R5", 32'(word_out), 32'h75AC3);

    // R7: every flag combination on data bytes, with words still forming
    for (int i = 0; i < 4 * NB; i++)
      step(8'(i * 5), 1'b0, i[0], i[1], "R6");

    // R3: back-to-back control characters, then a word
    step(8'hBC, 1'b1, 1'b0, 1'b0, "R3");
    step(8'hBC, 1'b1, 1'b1, 1'b0, "R3");
    for (int j = 0; j < NB; j++) step(8'(8'h81 + j), 1'b0, 1'b0, 1'b0, "R2");

    chk("R2", 32'(m_words > 256), 32'd1);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule